// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block moves board setup words between a 64-word by 16-bit three-wire serial EEPROM and a set of on-chip registers. Straight after hardware reset it reads the 48-bit station address (three words at a fixed location) and, unless the board straps select the built-in defaults, a configuration word and a base word whose EEPROM location is picked by a 3-bit strap code. This lets several identical boards sit in one system with only the straps changed.

Software can later ask for the same board-setup read again, or for the configuration and base registers to be saved back to the EEPROM. With the select bit set, the two requests instead move a single general-purpose word to or from an EEPROM word chosen by a 6-bit pointer. The block generates the serial clock, chip select and data-in itself. It handles write enabling and waits for the end of each write cycle, and it reports a busy flag for the whole sequence. Host bus decoding stays outside: the host reaches the registers through plain write strobes.

Top module: `eeprom_setup_loader`

## Requirements
- R1: Reset leaves `busy` high, `cfgReg`/`baseReg` at their default parameters and `gpReg` at zero. A board-setup read then runs by itself: word 0x20 lands in `stationAddr[15:0]`, word 0x21 in `[31:16]`, word 0x22 in `[47:32]`, `cfgReg` is loaded from word 4·s and `baseReg` from word 4·s+1, where s is the strap code.
- R2: With strap code 7, a board-setup read loads only the station address. `cfgReg` and `baseReg` keep the values they hold, which are the defaults after reset.
- R3: Writing the control word with bit 1 (reload) set and bit 2 (select) clear runs the board-setup read again. The strap code is the one present on the cycle of the request.
- R4: Writing bit 0 (store) with select clear writes `cfgReg` to word 4·s and `baseReg` to word 4·s+1. With strap code 7 a store causes no EEPROM traffic.
- R5: A reload with select set reads the word addressed by `wordPtr` into `gpReg`.
- R6: A store with select set writes `gpReg` to the word addressed by `wordPtr`.
- R7: Control word bits: bit 0 store, bit 1 reload, bit 2 select, with select readable on `selBit`. Reload and store read back 1 while their sequence runs and clear when `busy` falls. `busy` rises the cycle after an accepted request. When reload and store are requested together, only the reload runs.
- R8: While `busy` is high, control writes and register writes have no effect.
- R9: Each command raises chip select and sends a start bit of 1, a 2-bit opcode (read 10, write 01, write-enable 00 followed by address 11xxxx) and a 6-bit address, then 16 data bits, all MSB first. The serial clock runs with a period of 2·SK_HALF clocks and is high only while chip select is high. Data-in holds steady while the serial clock is high, and data-out is sampled on its rising edge.
- R10: Every write is preceded by a write-enable command. After each write, chip select goes low for a bit period and then high again until data-out reads 1. Only then does chip select drop and the next command start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; starts the board-setup read when released |
| strap | input | 3 | Board strap code selecting the configuration/base location |
| wordPtr | input | 6 | EEPROM word address for general-purpose transfers |
| ctlWe | input | 1 | Control word write strobe |
| ctlData | input | 3 | Control word: bit 0 store, bit 1 reload, bit 2 select |
| cfgWe | input | 1 | Configuration register write strobe |
| baseWe | input | 1 | Base register write strobe |
| gpWe | input | 1 | General-purpose register write strobe |
| hostData | input | 16 | Data for the register write strobes |
| eeDo | input | 1 | Serial data from the EEPROM |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| stationAddr | output | 48 | Station address from words 0x20..0x22 |
| cfgReg | output | 16 | Configuration register |
| baseReg | output | 16 | Base register |
| gpReg | output | 16 | General-purpose register |
| selBit | output | 1 | Select bit of the control word |
| reloadBit | output | 1 | Reload bit; high while a reload runs |
| storeBit | output | 1 | Store bit; high while a store runs |
| busy | output | 1 | High for the whole of a transfer sequence |

## Verification
The hardest situations to reach are the ones where something has to stay still: a request or register write that lands in the middle of a sequence, and the strap-7 store that must not touch the serial pins. The bench fires a store, a second reload and a configuration write a cycle after a reload starts. Once the loader is idle, it confirms that the configuration word is the loaded value, that the EEPROM model logged no write, and that `busy` stays low. A behavioural EEPROM model decodes every frame, times the serial clock, holds data-out low for a write-cycle interval, and refuses writes that arrive without a prior write-enable. A skipped enable or a missing poll therefore shows up as a wrong word in the model's memory or in its event log.

// File: rtl/eeprom_setup_pkg.sv
package eeprom_setup_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 16;
  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int STA_WORDS  = 3;

  typedef enum logic [1:0] {K_READ, K_WRITE, K_WEN} opKind_e;
  typedef enum logic [2:0] {T_STA0, T_STA1, T_STA2, T_CFG, T_BASE, T_GP} target_e;
  typedef enum logic [1:0] {J_BOARD_RD, J_BOARD_WR, J_GP_RD, J_GP_WR} job_e;

  typedef struct packed {
    logic    valid;
    opKind_e kind;
    target_e target;
  } opDesc_t;

  typedef struct packed {
    logic              load;
    logic              skRise;
    logic              sample;
    logic              skFall;
    logic              csDrop;
    logic              csRaise;
    logic              commit;
    opKind_e           kind;
    target_e           target;
    logic [ADDR_W-1:0] addr;
  } strobe_t;

  // Step i of a job; dflt means the strap code selects built-in defaults.
  function automatic opDesc_t lookupOp(input job_e j, input logic [2:0] i, input logic dflt);
    opDesc_t d;
    d = '{valid: 1'b0, kind: K_READ, target: T_GP};
    case (j)
      J_BOARD_RD: begin
        if (i < 3'd3)                d = '{1'b1, K_READ, target_e'(i)};
        else if (!dflt && i == 3'd3) d = '{1'b1, K_READ, T_CFG};
        else if (!dflt && i == 3'd4) d = '{1'b1, K_READ, T_BASE};
      end
      J_BOARD_WR: begin
        if (!dflt && i == 3'd0)      d = '{1'b1, K_WEN, T_GP};
        else if (!dflt && i == 3'd1) d = '{1'b1, K_WRITE, T_CFG};
        else if (!dflt && i == 3'd2) d = '{1'b1, K_WRITE, T_BASE};
      end
      J_GP_RD: if (i == 3'd0) d = '{1'b1, K_READ, T_GP};
      default: begin
        if (i == 3'd0)      d = '{1'b1, K_WEN, T_GP};
        else if (i == 3'd1) d = '{1'b1, K_WRITE, T_GP};
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/eeprom_setup_ctrl.sv
module eeprom_setup_ctrl import eeprom_setup_pkg::*; #(
  parameter int                SK_HALF  = 2,
  parameter int                STRAP_W  = 3,
  parameter logic [ADDR_W-1:0] STA_BASE = 6'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  logic [ADDR_W-1:0]  wordPtr,
  input  logic               ctlWe,
  input  logic [2:0]         ctlData,
  input  logic               eeDo,
  output strobe_t            str,
  output logic               busy,
  output logic               selBit,
  output logic               reloadBit,
  output logic               storeBit
);
  localparam int TICK_W = $clog2(2 * SK_HALF + 1);
  localparam int CNT_W  = $clog2(FRAME_BITS + 1);
  localparam logic [STRAP_W-1:0] DEFAULT_CODE = '1;

  typedef enum logic [2:0] {S_IDLE, S_BOOT, S_PREP, S_SHIFT, S_END, S_GAP, S_POLL, S_FIN} state_e;

  state_e              state;
  job_e                job;
  logic [2:0]          opIdx;
  logic [CNT_W-1:0]    bitCnt;
  logic [TICK_W-1:0]   tick;
  logic                skHi;
  logic                pollNext;
  logic [STRAP_W-1:0]  strapLat;
  logic [ADDR_W-1:0]   ptrLat;
  opDesc_t             desc;
  logic [ADDR_W-1:0]   opAddr;
  logic [CNT_W-1:0]    lastBit;
  logic [ADDR_W-1:0]   strapWord;

  assign desc      = lookupOp(job, opIdx, strapLat == DEFAULT_CODE);
  assign strapWord = ADDR_W'(strapLat) << 2;
  assign lastBit   = (desc.kind == K_WEN) ? CNT_W'(CMD_BITS - 1) : CNT_W'(FRAME_BITS - 1);
  assign busy      = (state != S_IDLE);

  always_comb begin
    case (desc.target)
      T_STA0:  opAddr = STA_BASE;
      T_STA1:  opAddr = STA_BASE + ADDR_W'(1);
      T_STA2:  opAddr = STA_BASE + ADDR_W'(2);
      T_CFG:   opAddr = strapWord;
      T_BASE:  opAddr = strapWord | ADDR_W'(1);
      default: opAddr = ptrLat;
    endcase
  end

  always_comb begin
    str        = '0;
    str.kind   = desc.kind;
    str.target = desc.target;
    str.addr   = opAddr;
    case (state)
      S_PREP:  str.load = desc.valid;
      S_SHIFT: if (tick == TICK_W'(SK_HALF - 1)) begin
        str.skRise = !skHi;
        str.sample = !skHi && desc.kind == K_READ && bitCnt >= CNT_W'(CMD_BITS);
        str.skFall = skHi;
      end
      S_END: begin
        str.csDrop = 1'b1;
        str.commit = desc.kind == K_READ;
      end
      S_GAP:   str.csRaise = pollNext && tick == TICK_W'(2 * SK_HALF - 1);
      S_POLL:  str.csDrop = eeDo;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_BOOT;
      job       <= J_BOARD_RD;
      opIdx     <= '0;
      bitCnt    <= '0;
      tick      <= '0;
      skHi      <= 1'b0;
      pollNext  <= 1'b0;
      strapLat  <= '0;
      ptrLat    <= '0;
      selBit    <= 1'b0;
      reloadBit <= 1'b0;
      storeBit  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (ctlWe) begin
          selBit   <= ctlData[2];
          strapLat <= strap;
          ptrLat   <= wordPtr;
          opIdx    <= '0;
          if (ctlData[1]) begin
            reloadBit <= 1'b1;
            job       <= ctlData[2] ? J_GP_RD : J_BOARD_RD;
            state     <= S_PREP;
          end else if (ctlData[0]) begin
            storeBit <= 1'b1;
            job      <= ctlData[2] ? J_GP_WR : J_BOARD_WR;
            state    <= S_PREP;
          end
        end
        S_BOOT: begin
          strapLat <= strap;
          state    <= S_PREP;
        end
        S_PREP: begin
          bitCnt <= '0;
          tick   <= '0;
          skHi   <= 1'b0;
          state  <= desc.valid ? S_SHIFT : S_FIN;
        end
        S_SHIFT: begin
          if (tick == TICK_W'(SK_HALF - 1)) begin
            tick <= '0;
            skHi <= !skHi;
            if (skHi) begin
              if (bitCnt == lastBit) state <= S_END;
              else bitCnt <= bitCnt + CNT_W'(1);
            end
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        S_END: begin
          pollNext <= desc.kind == K_WRITE;
          tick     <= '0;
          state    <= S_GAP;
        end
        S_GAP: begin
          if (tick == TICK_W'(2 * SK_HALF - 1)) begin
            tick <= '0;
            if (pollNext) begin
              pollNext <= 1'b0;
              state    <= S_POLL;
            end else begin
              opIdx <= opIdx + 3'd1;
              state <= S_PREP;
            end
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        S_POLL: if (eeDo) begin
          tick  <= '0;
          state <= S_GAP;
        end
        default: begin
          reloadBit <= 1'b0;
          storeBit  <= 1'b0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !reloadBit && !storeBit);
  a_r7_flag_implies_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reloadBit || storeBit) |-> busy);
  a_r8_start_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ctlWe));
endmodule

// File: rtl/eeprom_setup_dp.sv
module eeprom_setup_dp import eeprom_setup_pkg::*; #(
  parameter logic [DATA_W-1:0] CFG_DEFAULT  = 16'h00C0,
  parameter logic [DATA_W-1:0] BASE_DEFAULT = 16'h1840
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     str,
  input  logic                        busy,
  input  logic                        cfgWe,
  input  logic                        baseWe,
  input  logic                        gpWe,
  input  logic [DATA_W-1:0]           hostData,
  input  logic                        eeDo,
  output logic                        eeCs,
  output logic                        eeSk,
  output logic                        eeDi,
  output logic [STA_WORDS*DATA_W-1:0] stationAddr,
  output logic [DATA_W-1:0]           cfgReg,
  output logic [DATA_W-1:0]           baseReg,
  output logic [DATA_W-1:0]           gpReg
);
  logic [FRAME_BITS-1:0] txShift;
  logic [DATA_W-1:0]     rxShift;
  logic [1:0]            opcode;
  logic [ADDR_W-1:0]     frameAddr;
  logic [DATA_W-1:0]     frameData;

  always_comb begin
    case (str.kind)
      K_READ:  opcode = 2'b10;
      K_WRITE: opcode = 2'b01;
      default: opcode = 2'b00;
    endcase
    frameAddr = (str.kind == K_WEN) ? {2'b11, {(ADDR_W-2){1'b0}}} : str.addr;
    case (str.target)
      T_CFG:   frameData = cfgReg;
      T_BASE:  frameData = baseReg;
      T_GP:    frameData = gpReg;
      default: frameData = '0;
    endcase
    if (str.kind != K_WRITE) frameData = '0;
  end

  assign eeDi = txShift[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      eeCs    <= 1'b0;
      eeSk    <= 1'b0;
    end else begin
      if (str.load) begin
        txShift <= {1'b1, opcode, frameAddr, frameData};
        eeCs    <= 1'b1;
        eeSk    <= 1'b0;
      end
      if (str.skRise) eeSk <= 1'b1;
      if (str.sample) rxShift <= {rxShift[DATA_W-2:0], eeDo};
      if (str.skFall) begin
        eeSk    <= 1'b0;
        txShift <= txShift << 1;
      end
      if (str.csRaise) eeCs <= 1'b1;
      if (str.csDrop) begin
        eeCs    <= 1'b0;
        txShift <= '0;
      end
    end
  end

  for (genvar w = 0; w < STA_WORDS; w++) begin : g_sta
    logic [DATA_W-1:0] staWord;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) staWord <= '0;
      else if (str.commit && str.target == target_e'(3'(w))) staWord <= rxShift;
    end
    assign stationAddr[w*DATA_W +: DATA_W] = staWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= CFG_DEFAULT;
      baseReg <= BASE_DEFAULT;
      gpReg   <= '0;
    end else begin
      if (str.commit && str.target == T_CFG)       cfgReg  <= rxShift;
      else if (cfgWe && !busy)                     cfgReg  <= hostData;
      if (str.commit && str.target == T_BASE)      baseReg <= rxShift;
      else if (baseWe && !busy)                    baseReg <= hostData;
      if (str.commit && str.target == T_GP)        gpReg   <= rxShift;
      else if (gpWe && !busy)                      gpReg   <= hostData;
    end
  end

  a_r9_sk_within_cs: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> eeCs);
  a_r9_di_steady: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(str.commit && str.target == T_CFG)) |=> $stable(cfgReg));
  a_r8_gp_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(str.commit && str.target == T_GP)) |=> $stable(gpReg));
endmodule

// File: rtl/eeprom_setup_loader.sv
module eeprom_setup_loader import eeprom_setup_pkg::*; #(
  parameter int                SK_HALF      = 2,
  parameter int                STRAP_W      = 3,
  parameter logic [ADDR_W-1:0] STA_BASE     = 6'h20,
  parameter logic [DATA_W-1:0] CFG_DEFAULT  = 16'h00C0,
  parameter logic [DATA_W-1:0] BASE_DEFAULT = 16'h1840
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [STRAP_W-1:0]          strap,
  input  logic [ADDR_W-1:0]           wordPtr,
  input  logic                        ctlWe,
  input  logic [2:0]                  ctlData,
  input  logic                        cfgWe,
  input  logic                        baseWe,
  input  logic                        gpWe,
  input  logic [DATA_W-1:0]           hostData,
  input  logic                        eeDo,
  output logic                        eeCs,
  output logic                        eeSk,
  output logic                        eeDi,
  output logic [STA_WORDS*DATA_W-1:0] stationAddr,
  output logic [DATA_W-1:0]           cfgReg,
  output logic [DATA_W-1:0]           baseReg,
  output logic [DATA_W-1:0]           gpReg,
  output logic                        selBit,
  output logic                        reloadBit,
  output logic                        storeBit,
  output logic                        busy
);
  strobe_t str;

  eeprom_setup_ctrl #(.SK_HALF(SK_HALF), .STRAP_W(STRAP_W), .STA_BASE(STA_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .strap(strap), .wordPtr(wordPtr), .ctlWe(ctlWe),
    .ctlData(ctlData), .eeDo(eeDo), .str(str), .busy(busy), .selBit(selBit),
    .reloadBit(reloadBit), .storeBit(storeBit)
  );

  eeprom_setup_dp #(.CFG_DEFAULT(CFG_DEFAULT), .BASE_DEFAULT(BASE_DEFAULT)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .busy(busy), .cfgWe(cfgWe), .baseWe(baseWe),
    .gpWe(gpWe), .hostData(hostData), .eeDo(eeDo), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .stationAddr(stationAddr), .cfgReg(cfgReg), .baseReg(baseReg),
    .gpReg(gpReg)
  );
endmodule

// File: tb/eeprom_setup_loader_bench.sv
module eeprom_setup_loader_bench;
  localparam int          HALF     = 2;
  localparam logic [15:0] CFG_DEF  = 16'h00C0;
  localparam logic [15:0] BASE_DEF = 16'h1840;
  localparam int          WR_TIME  = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] strap = 3'd3;
  logic [5:0] wordPtr = '0;
  logic ctlWe = 1'b0, cfgWe = 1'b0, baseWe = 1'b0, gpWe = 1'b0;
  logic [2:0] ctlData = '0;
  logic [15:0] hostData = '0;
  logic eeDo, eeCs, eeSk, eeDi;
  logic [47:0] stationAddr;
  logic [15:0] cfgReg, baseReg, gpReg;
  logic selBit, reloadBit, storeBit, busy;

  always #2 clk = ~clk;

  eeprom_setup_loader #(.SK_HALF(HALF), .CFG_DEFAULT(CFG_DEF), .BASE_DEFAULT(BASE_DEF)) u_eeprom_setup_loader (
    .clk(clk), .rstN(rstN), .strap(strap), .wordPtr(wordPtr), .ctlWe(ctlWe),
    .ctlData(ctlData), .cfgWe(cfgWe), .baseWe(baseWe), .gpWe(gpWe), .hostData(hostData),
    .eeDo(eeDo), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi), .stationAddr(stationAddr),
    .cfgReg(cfgReg), .baseReg(baseReg), .gpReg(gpReg), .selBit(selBit),
    .reloadBit(reloadBit), .storeBit(storeBit), .busy(busy)
  );

  int nVec = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM model ----------------
  logic [15:0] mem [64];
  logic [24:0] rxBits = '0;
  int bitCnt = 0, wrBusy = 0, cyc = 0, lastRise = 0, pollCount = 0, protoErr = 0;
  bit wen = 1'b0, rdActive = 1'b0, skPrev = 1'b0, csPrev = 1'b0;
  logic [5:0] rdAddr = '0;
  int evLog[$];
  logic [21:0] wrLog[$];
  logic doVal;

  always_comb begin
    doVal = 1'b0;
    if (eeCs) begin
      if (rdActive && bitCnt >= 9 && bitCnt < 25) doVal = mem[rdAddr][24 - bitCnt];
      else if (bitCnt == 0) doVal = (wrBusy == 0);
    end
  end
  assign eeDo = doVal;

  always @(negedge clk) begin
    cyc++;
    if (wrBusy > 0) wrBusy--;
    if (eeSk && !skPrev) begin
      if (!eeCs) protoErr++;
      if (bitCnt == 0 && wrBusy > 0) protoErr++;
      if (bitCnt > 0 && cyc - lastRise != 2 * HALF) protoErr++;
      lastRise = cyc;
      rxBits = {rxBits[23:0], eeDi};
      bitCnt++;
      if (bitCnt == 9) begin
        rdActive = (rxBits[8:6] == 3'b110);
        rdAddr   = rxBits[5:0];
      end
    end
    if (!eeCs && csPrev) begin
      if (bitCnt == 9 && rxBits[8:4] == 5'b10011) begin
        evLog.push_back(1);
        wen = 1'b1;
      end else if (bitCnt == 25 && rxBits[24:22] == 3'b101) begin
        evLog.push_back(2);
        wrLog.push_back(rxBits[21:0]);
        if (wen) mem[rxBits[21:16]] = rxBits[15:0];
        wrBusy = WR_TIME;
      end else if (bitCnt == 25 && rxBits[24:22] == 3'b110) begin
      end else if (bitCnt == 0) begin
        pollCount++;
      end else begin
        protoErr++;
      end
      bitCnt = 0;
      rdActive = 1'b0;
    end
    skPrev = eeSk;
    csPrev = eeCs;
  end

  // ---------------- reference model and per-clock compare ----------------
  logic [47:0] expSta = '0;
  logic [15:0] expCfg = CFG_DEF, expBase = BASE_DEF, expGp = '0;
  bit cmpOn = 1'b0;
  string curReq = "R1";

  always @(negedge clk) begin
    if (cmpOn && !busy) begin
      chk({curReq, " registers"}, {stationAddr, cfgReg}, {expSta, expCfg});
      chk({curReq, " base/gp"}, {32'h0, baseReg, gpReg}, {32'h0, expBase, expGp});
    end
  end

  task automatic boardRead(input int s);
    expSta = {mem[6'h22], mem[6'h21], mem[6'h20]};
    if (s != 7) begin
      expCfg  = mem[6'(s * 4)];
      expBase = mem[6'(s * 4 + 1)];
    end
  endtask

  task automatic ctlWrite(input logic [2:0] v);
    @(negedge clk);
    ctlData = v;
    ctlWe = 1'b1;
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic hostWrite(input int which, input logic [15:0] v);
    @(negedge clk);
    hostData = v;
    cfgWe  = (which == 0);
    baseWe = (which == 1);
    gpWe   = (which == 2);
    @(negedge clk);
    cfgWe = 1'b0; baseWe = 1'b0; gpWe = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  task automatic doReset(input logic [2:0] s);
    cmpOn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd1);
    chk("R1 reset defaults", {32'h0, cfgReg, baseReg}, {32'h0, CFG_DEF, BASE_DEF});
    chk("R1 gp reset", 64'(gpReg), 64'd0);
    waitIdle();
    expCfg = CFG_DEF; expBase = BASE_DEF; expGp = '0;
    boardRead(s);
  endtask

  initial begin
    int busyHigh;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0111) ^ 16'h5A00;

    // R1: boot read at strap 3
    doReset(3'd3);
    chk("R1 station", stationAddr, {mem[6'h22], mem[6'h21], mem[6'h20]});
    chk("R1 cfg/base", {32'h0, cfgReg, baseReg}, {32'h0, mem[12], mem[13]});
    curReq = "R1"; cmpOn = 1'b1;
    repeat (5) @(negedge clk);

    // R3 + R8: reload, then requests and register write while busy
    cmpOn = 1'b0;
    mem[6'h20] = 16'hA5A5;
    evLog.delete();
    ctlWrite(3'b010);
    chk("R7 busy after request", {62'h0, busy, reloadBit}, 64'd3);
    hostWrite(0, 16'hDEAD);
    ctlWrite(3'b001);
    ctlWrite(3'b010);
    waitIdle();
    boardRead(3);
    chk("R3 reload station word", 64'(stationAddr[15:0]), 64'hA5A5);
    chk("R8 cfg write ignored", 64'(cfgReg), 64'(mem[12]));
    chk("R8 store ignored", 64'(evLog.size()), 64'd0);
    busyHigh = 0;
    repeat (20) begin @(negedge clk); if (busy) busyHigh++; end
    chk("R8 second reload ignored", 64'(busyHigh), 64'd0);
    curReq = "R3"; cmpOn = 1'b1;

    // R4 + R10: store at strap 2
    strap = 3'd2;
    hostWrite(0, 16'h1357); expCfg = 16'h1357;
    hostWrite(1, 16'h2468); expBase = 16'h2468;
    cmpOn = 1'b0;
    evLog.delete(); wrLog.delete(); pollCount = 0;
    ctlWrite(3'b001);
    chk("R7 store flag", 64'(storeBit), 64'd1);
    waitIdle();
    chk("R10 enable then writes", 64'(evLog.size() == 3 && evLog[0] == 1 && evLog[1] == 2 && evLog[2] == 2), 64'd1);
    chk("R4 first write", 64'(wrLog[0]), {42'h0, 6'd8, 16'h1357});
    chk("R4 second write", 64'(wrLog[1]), {42'h0, 6'd9, 16'h2468});
    chk("R4 memory", {32'h0, mem[8], mem[9]}, {32'h0, 16'h1357, 16'h2468});
    chk("R10 polls", 64'(pollCount), 64'd2);
    chk("R7 store cleared", {62'h0, reloadBit, storeBit}, 64'd0);
    curReq = "R4"; cmpOn = 1'b1;

    // R3: reload at strap 2 returns the stored words
    cmpOn = 1'b0;
    hostWrite(0, 16'h0000);
    ctlWrite(3'b010);
    waitIdle();
    boardRead(2);
    chk("R3 reload strap 2", 64'(cfgReg), 64'h1357);
    curReq = "R3"; cmpOn = 1'b1;

    // R2 and R4: strap 7 reload and store
    strap = 3'd7;
    cmpOn = 1'b0;
    hostWrite(0, 16'h0F0F); expCfg = 16'h0F0F;
    mem[6'h21] = 16'h3C3C;
    ctlWrite(3'b010);
    waitIdle();
    boardRead(7);
    chk("R2 cfg kept", {32'h0, cfgReg, baseReg}, {32'h0, 16'h0F0F, mem[9]});
    chk("R2 station", 64'(stationAddr[31:16]), 64'h3C3C);
    evLog.delete();
    ctlWrite(3'b001);
    waitIdle();
    chk("R4 strap 7 no traffic", 64'(evLog.size()), 64'd0);
    curReq = "R2"; cmpOn = 1'b1;

    // R5: general-purpose read
    cmpOn = 1'b0;
    wordPtr = 6'h2A;
    ctlWrite(3'b110);
    waitIdle();
    expGp = mem[6'h2A];
    chk("R5 gp read", 64'(gpReg), 64'(mem[6'h2A]));
    chk("R7 select readable", 64'(selBit), 64'd1);
    curReq = "R5"; cmpOn = 1'b1;

    // R6: general-purpose write
    hostWrite(2, 16'hBEEF); expGp = 16'hBEEF;
    cmpOn = 1'b0;
    wordPtr = 6'h05;
    evLog.delete(); wrLog.delete(); pollCount = 0;
    ctlWrite(3'b101);
    waitIdle();
    chk("R6 memory", 64'(mem[5]), 64'hBEEF);
    chk("R6 frame", 64'(wrLog.size() == 1 && wrLog[0] == {6'd5, 16'hBEEF}), 64'd1);
    chk("R10 gp enable first", 64'(evLog.size() == 2 && evLog[0] == 1), 64'd1);
    chk("R10 gp poll", 64'(pollCount), 64'd1);
    curReq = "R6"; cmpOn = 1'b1;

    // R7: reload and store together, select clear, strap 4
    strap = 3'd4;
    cmpOn = 1'b0;
    mem[6'h22] = 16'h7E81;
    evLog.delete();
    ctlWrite(3'b011);
    waitIdle();
    boardRead(4);
    chk("R7 reload wins", 64'(evLog.size()), 64'd0);
    chk("R7 reload ran", 64'(stationAddr[47:32]), 64'h7E81);
    chk("R7 flags clear", {61'h0, selBit, reloadBit, storeBit}, 64'd0);
    curReq = "R7"; cmpOn = 1'b1;

    // R2: reset with strap 7 keeps defaults
    doReset(3'd7);
    chk("R2 defaults after boot", {32'h0, cfgReg, baseReg}, {32'h0, CFG_DEF, BASE_DEF});
    curReq = "R2"; cmpOn = 1'b1;
    repeat (5) @(negedge clk);

    chk("R9 serial protocol errors", 64'(protoErr), 64'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule